// File: doc/BRIEF.md
# System Management Interrupt Handshake Controller

This block runs the handshake on a shared, active-low system management interrupt line. While idle, the line is an input. The block looks for a low level that holds for a minimum number of samples. When it recognizes one, it raises a management interrupt request to the core. After a fixed delay it takes over the line and drives it low for as long as the service routine runs. When the core reports that the resume instruction has retired, the block drives the line high for a short, fixed pulse and then releases it. It does not arm again until the line reads high.

The core-facing requests give the management interrupt precedence over the ordinary non-maskable interrupt. The non-maskable request is blocked whenever the handshake is not idle. The block also splits the bus unit's address-strobe request into a normal strobe and a management-memory strobe. Both strobes go through the same register stage, so they share the same timing.

Top module: `smi_handshake_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `pin_oe_o`, `pin_o`, `smi_req_o`, `nmi_req_o`, `ads_o` and `mads_o` are all 0.
- R2: When the line is sampled low (0) on LOW_MIN consecutive rising edges while idle, `smi_req_o` is 1 after the LOW_MIN-th of those edges. It stays 1 until the resume report is sampled.
- R3: A low run shorter than LOW_MIN samples, ended by a high sample, causes no entry. The next low run starts its count from zero.
- R4: Exactly ENTRY_DLY clock edges after the recognizing edge, `pin_oe_o` becomes 1 with `pin_o` at 0.
- R5: `pin_oe_o`=1 and `pin_o`=0 hold for every cycle until `rsm_done_i` is sampled 1.
- R6: After the edge that samples `rsm_done_i`=1, `pin_oe_o`=1 and `pin_o`=1 for exactly HIGH_PULSE cycles. Then `pin_oe_o` returns to 0 and `smi_req_o` is 0.
- R7: `pin_oe_o` is 0 while idle, while counting the low run, during the entry delay, and after release.
- R8: After release, the block ignores a line held low until it samples the line high once. A later entry again needs LOW_MIN fresh low samples.
- R9: `nmi_req_o` follows `nmi_i` only while the handshake is idle. It is 0 from recognition until the line is released and read high. `smi_req_o` and `nmi_req_o` are never 1 together.
- R10: One cycle after `bus_start_i` is sampled 1, either `mads_o`=1 (when `mm_cycle_i` was 1) or `ads_o`=1 (when `mm_cycle_i` was 0). The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the line is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Sampled level of the interrupt line (low = active) |
| pin_o | output | 1 | Value driven onto the line when enabled |
| pin_oe_o | output | 1 | Output enable for the line |
| rsm_done_i | input | 1 | Core reports the resume instruction has retired |
| nmi_i | input | 1 | Ordinary non-maskable interrupt request |
| smi_req_o | output | 1 | Management interrupt request to the core |
| nmi_req_o | output | 1 | Gated non-maskable interrupt request to the core |
| bus_start_i | input | 1 | Bus unit starts a memory cycle |
| mm_cycle_i | input | 1 | Cycle targets management-mode memory |
| ads_o | output | 1 | Normal address strobe |
| mads_o | output | 1 | Management-memory address strobe |

## Verification
The bench builds the block with its defaults: LOW_MIN=4, ENTRY_DLY=4 and HIGH_PULSE=2. With these values the bench can test low runs of one, two and three samples against the four-sample threshold, and it can count the entry delay and the high pulse cycle by cycle. The delay and the pulse differ in length, so a counter that reloads the wrong limit gives the wrong cycle count and is caught. The small threshold also makes the re-arm case quick to reach: a line held low after release for many more than four cycles must still not cause a new entry.

// File: rtl/smi_hs_pkg.sv
`timescale 1ns/1ps
package smi_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_DRV_LO,
    ST_DRV_HI,
    ST_WAIT_HI
  } hs_state_e;
endpackage

// File: rtl/smi_pin_qual.sv
`timescale 1ns/1ps
module smi_pin_qual #(
  parameter int LOW_MIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic arm_i,
  output logic hit_o
);
  localparam int CW = $clog2(LOW_MIN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(LOW_MIN - 1);
  localparam logic [CW-1:0] RUN_SAT  = CW'(LOW_MIN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (!arm_i || pin_i)  run_q <= '0;
    else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
  end

  assign hit_o = arm_i && !pin_i && (run_q == RUN_LAST);

  generate
    if (LOW_MIN > 1) begin : g_chk
      // a high sample restarts the run, so the next sample cannot qualify
      assert_run_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_i |=> !hit_o);
    end
  endgenerate
endmodule

// File: rtl/smi_hs_fsm.sv
`timescale 1ns/1ps
module smi_hs_fsm
  import smi_hs_pkg::*;
#(
  parameter int ENTRY_DLY  = 4,
  parameter int HIGH_PULSE = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  logic      hit_i,
  input  logic      rsm_done_i,
  output hs_state_e state_o,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      arm_o
);
  localparam int MAXD = (ENTRY_DLY > HIGH_PULSE) ? ENTRY_DLY : HIGH_PULSE;
  localparam int DW   = $clog2(MAXD + 1);
  localparam logic [DW-1:0] ENTRY_LAST = DW'(ENTRY_DLY - 1);
  localparam logic [DW-1:0] HIGH_LAST  = DW'(HIGH_PULSE - 1);

  hs_state_e     state_q, state_d;
  logic [DW-1:0] dly_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (hit_i)                   state_d = ST_ENTRY;
      ST_ENTRY:   if (dly_q == ENTRY_LAST)     state_d = ST_DRV_LO;
      ST_DRV_LO:  if (rsm_done_i)              state_d = ST_DRV_HI;
      ST_DRV_HI:  if (dly_q == HIGH_LAST)      state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (pin_i)                   state_d = ST_IDLE;
      default:                                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= (state_d != state_q) ? '0 : dly_q + 1'b1;
    end
  end

  assign state_o  = state_q;
  assign pin_oe_o = (state_q == ST_DRV_LO) || (state_q == ST_DRV_HI);
  assign pin_o    = (state_q == ST_DRV_HI);
  assign arm_o    = (state_q == ST_IDLE);

  assert_drive_starts_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o) |-> !pin_o);
  assert_hold_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRV_LO && !rsm_done_i) |=> (pin_oe_o && !pin_o));
  assert_release_after_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_oe_o) |-> $past(pin_o));
  assert_no_rearm_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_HI && !pin_i) |=> !arm_o);
endmodule

// File: rtl/smi_strobe_gen.sv
`timescale 1ns/1ps
module smi_strobe_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_start_i,
  input  logic mm_cycle_i,
  output logic ads_o,
  output logic mads_o
);
  // both strobes share one register stage so their timing is identical
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ads_o  <= 1'b0;
      mads_o <= 1'b0;
    end else begin
      ads_o  <= bus_start_i && !mm_cycle_i;
      mads_o <= bus_start_i &&  mm_cycle_i;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ads_o, mads_o}));
  assert_mads_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mads_o |-> $past(mm_cycle_i));
endmodule

// File: rtl/smi_handshake_ctrl.sv
`timescale 1ns/1ps
module smi_handshake_ctrl
  import smi_hs_pkg::*;
#(
  parameter int LOW_MIN    = 4,
  parameter int ENTRY_DLY  = 4,
  parameter int HIGH_PULSE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  input  logic rsm_done_i,
  input  logic nmi_i,
  output logic smi_req_o,
  output logic nmi_req_o,
  input  logic bus_start_i,
  input  logic mm_cycle_i,
  output logic ads_o,
  output logic mads_o
);
  hs_state_e state;
  logic      hit, arm;

  smi_pin_qual #(.LOW_MIN(LOW_MIN)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .arm_i (arm),
    .hit_o (hit)
  );

  smi_hs_fsm #(.ENTRY_DLY(ENTRY_DLY), .HIGH_PULSE(HIGH_PULSE)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_i),
    .hit_i     (hit),
    .rsm_done_i(rsm_done_i),
    .state_o   (state),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .arm_o     (arm)
  );

  smi_strobe_gen u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_start_i(bus_start_i),
    .mm_cycle_i (mm_cycle_i),
    .ads_o      (ads_o),
    .mads_o     (mads_o)
  );

  assign smi_req_o = (state == ST_ENTRY) || (state == ST_DRV_LO);
  assign nmi_req_o = nmi_i && (state == ST_IDLE);

  assert_req_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smi_req_o && nmi_req_o));
  assert_req_on_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> smi_req_o);
endmodule

// File: tb/tb_smi_handshake_ctrl.sv
`timescale 1ns/1ps
module tb_smi_handshake_ctrl;
  localparam int LOW_MIN    = 4;
  localparam int ENTRY_DLY  = 4;
  localparam int HIGH_PULSE = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_lvl = 1'b1;
  logic pin_o, pin_oe_o, rsm_done_i = 1'b0, nmi_i = 1'b0;
  logic smi_req_o, nmi_req_o, bus_start_i = 1'b0, mm_cycle_i = 1'b0;
  logic ads_o, mads_o;
  logic pin_w;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;

  assign pin_w = pin_oe_o ? pin_o : ext_lvl;

  smi_handshake_ctrl #(.LOW_MIN(LOW_MIN), .ENTRY_DLY(ENTRY_DLY), .HIGH_PULSE(HIGH_PULSE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin_w), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .rsm_done_i(rsm_done_i), .nmi_i(nmi_i), .smi_req_o(smi_req_o), .nmi_req_o(nmi_req_o),
    .bus_start_i(bus_start_i), .mm_cycle_i(mm_cycle_i), .ads_o(ads_o), .mads_o(mads_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] exp_strobes(input logic st, input logic mm);
    return {st && mm, st && !mm};
  endfunction

  task automatic enter();
    ext_lvl = 1'b0;
    for (int i = 0; i < LOW_MIN - 1; i++) begin
      tick();
      chk(smi_req_o == 1'b0, "R2 early", smi_req_o, 0);
    end
    tick();
    chk(smi_req_o == 1'b1, "R2 recog", smi_req_o, 1);
    ext_lvl = 1'b1;
    for (int i = 1; i < ENTRY_DLY; i++) begin
      tick();
      chk(pin_oe_o == 1'b0, "R7 entry delay", pin_oe_o, 0);
    end
    tick();
    chk(pin_oe_o == 1'b1 && pin_o == 1'b0, "R4 drive low", {pin_oe_o, pin_o}, 2);
  endtask

  task automatic serve(input int n);
    for (int i = 0; i < n; i++) begin
      nmi_i = 1'($urandom_range(0, 1));
      #1;
      chk(nmi_req_o == 1'b0, "R9 nmi held", nmi_req_o, 0);
      tick();
      chk(pin_oe_o && !pin_o && smi_req_o, "R5 service", {pin_oe_o, pin_o, smi_req_o}, 5);
    end
    nmi_i = 1'b0;
  endtask

  task automatic resume();
    rsm_done_i = 1'b1;
    tick();
    rsm_done_i = 1'b0;
    chk(pin_oe_o && pin_o && !smi_req_o, "R6 high pulse", {pin_oe_o, pin_o, smi_req_o}, 6);
    for (int i = 1; i < HIGH_PULSE; i++) begin
      tick();
      chk(pin_oe_o && pin_o, "R6 high pulse", {pin_oe_o, pin_o}, 3);
    end
    tick();
    chk(pin_oe_o == 1'b0, "R6 release", pin_oe_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] exp_s;
    int run;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk({pin_oe_o, pin_o, smi_req_o, nmi_req_o, ads_o, mads_o} == 6'b0, "R1 in reset",
        {pin_oe_o, pin_o, smi_req_o, nmi_req_o, ads_o, mads_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk({pin_oe_o, pin_o, smi_req_o, nmi_req_o, ads_o, mads_o} == 6'b0, "R1 after reset",
        {pin_oe_o, pin_o, smi_req_o, nmi_req_o, ads_o, mads_o}, 0);

    // directed: 3 low, 1 high, 3 low must not enter
    for (int k = 0; k < 7; k++) begin
      ext_lvl = (k == 3);
      tick();
      chk(smi_req_o == 1'b0 && pin_oe_o == 1'b0, "R3 split run", smi_req_o, 0);
    end
    ext_lvl = 1'b1;
    tick();

    // random short runs, NMI pass-through and strobes while idle
    run = 0;
    exp_s = 2'b00;
    for (int k = 0; k < 400; k++) begin
      logic lvl;
      lvl = 1'($urandom_range(0, 1));
      if (!lvl && run == LOW_MIN - 1) lvl = 1'b1;
      run = lvl ? 0 : run + 1;
      ext_lvl = lvl;
      nmi_i = 1'($urandom_range(0, 1));
      bus_start_i = 1'($urandom_range(0, 1));
      mm_cycle_i = 1'($urandom_range(0, 1));
      exp_s = exp_strobes(bus_start_i, mm_cycle_i);
      #1;
      chk(nmi_req_o == nmi_i, "R9 idle pass", nmi_req_o, nmi_i);
      tick();
      chk(smi_req_o == 1'b0 && pin_oe_o == 1'b0, "R3 short run", {smi_req_o, pin_oe_o}, 0);
      chk({mads_o, ads_o} == exp_s, "R10 strobe", {mads_o, ads_o}, exp_s);
    end
    ext_lvl = 1'b1; nmi_i = 1'b0; bus_start_i = 1'b0;
    tick();
    chk({mads_o, ads_o} == 2'b00, "R10 idle strobe", {mads_o, ads_o}, 0);

    // several full handshakes
    for (int h = 0; h < 5; h++) begin
      enter();
      serve($urandom_range(1, 20));
      resume();
      tick();
      nmi_i = 1'b1;
      #1;
      chk(nmi_req_o == 1'b1, "R9 after idle", nmi_req_o, 1);
      nmi_i = 1'b0;
      tick();
    end

    // line left low after release must not re-enter
    enter();
    serve(3);
    resume();
    ext_lvl = 1'b0;
    for (int k = 0; k < 12; k++) begin
      nmi_i = 1'b1;
      #1;
      chk(nmi_req_o == 1'b0, "R9 wait high", nmi_req_o, 0);
      tick();
      chk(smi_req_o == 1'b0 && pin_oe_o == 1'b0, "R8 no reentry", {smi_req_o, pin_oe_o}, 0);
    end
    nmi_i = 1'b0;
    ext_lvl = 1'b1;
    tick();
    enter();
    serve(2);
    resume();
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule